// File: doc/BRIEF.md
# Packed Decimal Four-Digit Adder

This block adds two packed decimal numbers, each holding four decimal digits, plus a one-bit carry-in, and returns the packed decimal sum and a decimal carry-out. It is purely combinational. Inputs can be applied at any time, and the outputs settle within the same cycle.

Each digit position is handled by its own stage, in three steps:
- A 4-bit binary adder forms the raw total of the two digits and the incoming carry, together with a binary carry.
- A detector flags when that raw total cannot be written as a single decimal digit.
- When flagged, six is added to the raw 4-bit value. The low four bits become the output digit, and the flag becomes the decimal carry into the next more significant digit.

The carry ripples from the ones digit through the tens and hundreds digits to the thousands digit.

Top module: `bcd_add_chain`

## Requirements
- R1: With both operands zero and carry-in zero, the sum is 16'h0000 and the carry-out is 0.
- R2: For a digit position whose two digits (each 0..9) plus incoming carry total 0..9, the output digit equals that total and no carry passes to the next digit.
- R3: For a digit position whose two digits plus incoming carry total 10..19, the output digit equals the total minus 10 and a carry of 1 passes to the next digit. Examples: 8 + 5 gives digit 3 with carry 1, and 9 + 9 + 1 gives digit 9 with carry 1.
- R4: For operands whose nibbles are all 0..9, every nibble of sum_o is in 0..9.
- R5: The carry ripples from the ones digit (bits 3:0) to the thousands digit (bits 15:12). 0999 + 0001 gives 1000, and 9999 + 0000 with carry-in 1 gives 0000 with carry-out 1.
- R6: For valid operands, value(sum_o) + 10000 * carry_o equals value(a_i) + value(b_i) + carry_i. Example: 2905 + 1897 gives 4802 with carry-out 0.
- R7: Digit correction is triggered when the raw binary digit sum z has z3 AND (z2 OR z1), or when its binary carry is set. In that case the output digit is (z + 6) mod 16 and the digit carry is 1.
- R8: Invalid nibbles (10..15) follow R7 with no further handling. F + F + carry 1 gives digit 5 with carry 1, and A + 0 gives digit 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, four packed decimal digits, ones in bits 3:0 |
| b_i | input | 16 | Second operand, same packing |
| carry_i | input | 1 | Carry into the ones digit |
| sum_o | output | 16 | Packed decimal sum |
| carry_o | output | 1 | Decimal carry out of the thousands digit |

## Verification
The digit-level and whole-word assertions assume that every operand nibble is a valid decimal digit (0..9). Each assertion is guarded by that condition, so it is silent when a nibble is 10..15.

The sweeps and random operands draw each nibble only from 0..9. Invalid nibbles appear only in a few directed vectors, and those vectors are compared against the fixed hex results given in R8.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DEC_MAX = 4'd9;
  localparam digit_t DEC_FIX = 4'd6;
endpackage

// File: rtl/bcd_bin_add4.sv
module bcd_bin_add4
  import bcd_add_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   c_i,
  output digit_t z_o,
  output logic   c_o
);
  logic [DIGIT_W:0] full;
  assign full = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, c_i};
  assign z_o  = full[DIGIT_W-1:0];
  assign c_o  = full[DIGIT_W];
endmodule

// File: rtl/bcd_dec_fix.sv
module bcd_dec_fix
  import bcd_add_pkg::*;
(
  input  digit_t z_i,
  input  logic   bc_i,
  output digit_t digit_o,
  output logic   c_o
);
  logic   over9;
  digit_t adj;
  // raw nibble above nine: 1010..1111
  assign over9   = z_i[3] & (z_i[2] | z_i[1]);
  assign c_o     = over9 | bc_i;
  assign adj     = c_o ? DEC_FIX : '0;
  assign digit_o = z_i + adj;
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_add_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   c_i,
  output digit_t digit_o,
  output logic   c_o
);
  digit_t z;
  logic   bc;

  bcd_bin_add4 i_bin (
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .z_o(z), .c_o(bc)
  );

  bcd_dec_fix i_fix (
    .z_i(z), .bc_i(bc), .digit_o(digit_o), .c_o(c_o)
  );

  logic       in_ok;
  logic [4:0] tot;
  assign in_ok = (a_i <= DEC_MAX) && (b_i <= DEC_MAX);
  assign tot   = 5'(a_i) + 5'(b_i) + 5'(c_i);

  always_comb begin
    a_r4_digit_range: assert (!in_ok || digit_o <= DEC_MAX);
    a_r2_low_total: assert (!(in_ok && tot <= 5'd9) || (digit_o == tot[3:0] && !c_o));
    a_r3_high_total: assert (!(in_ok && tot >= 5'd10) || (digit_o == 4'(tot - 5'd10) && c_o));
    // R7: correction only when raw total leaves the single-digit range
    a_r7_fix_iff_over: assert (!in_ok || (c_o == (tot >= 5'd10)));
  end
endmodule

// File: rtl/bcd_add_chain.sv
module bcd_add_chain
  import bcd_add_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] a_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] b_i,
  input  logic                          carry_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] sum_o,
  output logic                          carry_o
);
  localparam int WORD_W = NUM_DIGITS * DIGIT_W;

  logic [NUM_DIGITS:0] chain;
  assign chain[0] = carry_i;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    bcd_digit_stage i_stage (
      .a_i    (a_i[d*DIGIT_W +: DIGIT_W]),
      .b_i    (b_i[d*DIGIT_W +: DIGIT_W]),
      .c_i    (chain[d]),
      .digit_o(sum_o[d*DIGIT_W +: DIGIT_W]),
      .c_o    (chain[d+1])
    );
  end

  assign carry_o = chain[NUM_DIGITS];

  function automatic longint dec_val(input logic [WORD_W-1:0] w);
    longint v = 0;
    for (int i = NUM_DIGITS-1; i >= 0; i--) v = v*10 + longint'(w[i*DIGIT_W +: DIGIT_W]);
    return v;
  endfunction

  function automatic logic all_ok(input logic [WORD_W-1:0] w);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) if (w[i*DIGIT_W +: DIGIT_W] > DEC_MAX) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint pow10(input int n);
    longint p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

  always_comb begin
    a_r6_decimal_total: assert (!(all_ok(a_i) && all_ok(b_i)) ||
      (dec_val(sum_o) + (carry_o ? pow10(NUM_DIGITS) : 0) ==
       dec_val(a_i) + dec_val(b_i) + longint'(carry_i)));
  end
endmodule

// File: tb/test_bcd_add_chain.sv
module test_bcd_add_chain;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a, b, sum;
  logic cin, cout;
  int errors = 0, checks = 0;
  bit done = 0;

  bcd_add_chain i_bcd_add_chain (
    .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum), .carry_o(cout)
  );

  function automatic int from_bcd(input logic [15:0] w);
    return w[15:12]*1000 + w[11:8]*100 + w[7:4]*10 + w[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v/1000%10), 4'(v/100%10), 4'(v/10%10), 4'(v%10)};
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    @(posedge clk); #1;
  endtask

  task automatic expect_raw(input string tag, input logic [15:0] es, input logic ec);
    checks++;
    if (sum !== es || cout !== ec) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0b got sum=%h cout=%0b expected sum=%h cout=%0b",
               tag, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic expect_model(input string tag);
    int t;
    t = from_bcd(a) + from_bcd(b) + int'(cin);
    expect_raw(tag, to_bcd(t % 10000), t >= 10000);
  endtask

  function automatic logic [15:0] rnd_bcd();
    return {4'($urandom_range(0,9)), 4'($urandom_range(0,9)),
            4'($urandom_range(0,9)), 4'($urandom_range(0,9))};
  endfunction

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1 idle state
    drive(16'h0000, 16'h0000, 1'b0);
    expect_raw("R1", 16'h0000, 1'b0);
    // R3 directed digit cases
    drive(16'h0008, 16'h0005, 1'b0);
    expect_raw("R3", 16'h0013, 1'b0);
    drive(16'h0009, 16'h0009, 1'b1);
    expect_raw("R3", 16'h0019, 1'b0);
    drive(16'h9000, 16'h9000, 1'b1);
    expect_raw("R3", 16'h8001, 1'b1);
    // R5 ripple across all digits
    drive(16'h0999, 16'h0001, 1'b0);
    expect_raw("R5", 16'h1000, 1'b0);
    drive(16'h9999, 16'h0000, 1'b1);
    expect_raw("R5", 16'h0000, 1'b1);
    // R6 worked example
    drive(16'h2905, 16'h1897, 1'b0);
    expect_raw("R6", 16'h4802, 1'b0);
    // R7 / R8 invalid nibble behaviour
    drive(16'h000F, 16'h000F, 1'b1);
    expect_raw("R8", 16'h0015, 1'b0);
    drive(16'h000A, 16'h0000, 1'b0);
    expect_raw("R7", 16'h0010, 1'b0);
    // R2 / R3 exhaustive per digit position
    for (int p = 0; p < 4; p++)
      for (int x = 0; x < 10; x++)
        for (int y = 0; y < 10; y++)
          for (int c = 0; c < 2; c++) begin
            drive(16'(x) << (4*p), 16'(y) << (4*p), 1'(c));
            expect_model((x + y + (p == 0 ? c : 0)) <= 9 ? "R2" : "R3");
          end
    // R6 / R4 random operands
    for (int n = 0; n < 3000; n++) begin
      drive(rnd_bcd(), rnd_bcd(), 1'($urandom_range(0,1)));
      expect_model("R6");
      checks++;
      if (sum[3:0] > 9 || sum[7:4] > 9 || sum[11:8] > 9 || sum[15:12] > 9) begin
        errors++;
        $display("FAIL R4: sum=%h has nibble above 9, expected all nibbles 0..9", sum);
      end
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule